// File: doc/BRIEF.md
# I2C Register Read Master

This block is an I2C bus controller that reads one or more consecutive bytes from the register space of a target device. The host supplies a 7-bit target address, an 8-bit starting register index and a byte count, and then pulses `go`. The controller runs the combined-format sequence without further help. It sends a start and the address with the write direction, then the register index, then a repeated start and the address with the read direction. It then clocks in the requested number of bytes.

Each received byte appears on `rd_data` together with a one-cycle `rd_valid` pulse. The controller acknowledges every byte except the final one. The final byte gets a not-acknowledge and is followed by a stop. At the end of every request, `done` pulses for one cycle. `error` pulses in the same cycle when the request was refused or the target failed to acknowledge an address or register-index byte.

Both bus lines are open-drain. An `*_oe` output at 1 pulls its line low, and 0 releases it to the pull-up. Every bit on the bus lasts four quarter-phases, and each quarter-phase lasts `CLK_DIV` clock cycles.

Top module: `i2c_regread_master`

## Requirements
- R1: A `go` with `byte_cnt` equal to 0 produces `done` and `error` high in the cycle after `go` is sampled. It causes no bus activity: no start condition appears and both `scl_oe` and `sda_oe` stay 0.
- R2: A request opens with a start condition (SDA falls while SCL is high). The 7-bit target address follows, most significant bit first, then a direction bit of 0.
- R3: After the target acknowledges the address, the controller sends the 8-bit register index most significant bit first. It then samples the target's acknowledge bit.
- R4: After the register index is acknowledged, a repeated start follows with no stop before it. The target address is then sent again with a direction bit of 1.
- R5: Data bits are taken most significant bit first. Each completed byte is presented on `rd_data` with a single-cycle `rd_valid`. A target that steps its index by one per byte therefore yields bytes from indices start, start+1, … modulo 256, in that order. `rd_valid` never pulses outside a request.
- R6: The controller drives an acknowledge (SDA low) after every received byte except the last. After the last byte it leaves SDA high (not-acknowledge) and issues exactly one stop. Outside a request both lines are released. A count of 1 gives a single byte with a not-acknowledge.
- R7: A not-acknowledge on either address byte or on the register index ends the request with one stop. `done` and `error` then pulse together and no byte is delivered. `error` never pulses without `done`.
- R8: Apart from start and stop conditions, the controller changes SDA only while SCL is low.
- R9: Every SCL high phase that begins after a request's start condition lasts exactly 2·`CLK_DIV` clock cycles.
- R10: A `go` pulse that arrives while a request is in progress is ignored. The running request completes unchanged and produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Single-cycle request strobe, accepted only when idle |
| tgt_addr | input | 7 | Target device address |
| sub_addr | input | 8 | First register index to read |
| byte_cnt | input | 8 | Number of bytes to read; 0 is refused |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse at the end of every request |
| error | output | 1 | Pulses with `done` on a refused request or missing acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some properties are checked on every cycle. SDA may move under a high SCL only while a start or stop is being generated. Both lines are released whenever no request is open. `error` never appears without `done`. A zero count answers at once and leaves the bus untouched. `rd_valid` occurs only inside a request.

Other behaviour depends on what the target answers, so only the bench's scenarios with a modelled target can show it. These scenarios cover the bit order of the address and index bytes, the direction bits, and the repeated start with no intervening stop. They also cover the data order across an index wrap, the pattern of acknowledges ending in a single not-acknowledge, each of the three refusal points, the SCL high width, and a stray `go` mid-request.

// File: rtl/i2c_rd_pkg.sv
`timescale 1ns/1ps
package i2c_rd_pkg;

  // bit-level operations carried out by the quarter-phase engine
  typedef enum logic [1:0] {
    PCMD_START = 2'd0,
    PCMD_STOP  = 2'd1,
    PCMD_WRITE = 2'd2,
    PCMD_READ  = 2'd3
  } pcmd_e;

  // byte-level sequencer states
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_TX    = 3'd2,
    S_TXACK = 3'd3,
    S_RX    = 3'd4,
    S_RXACK = 3'd5,
    S_STOP  = 3'd6
  } seq_e;

  // which byte of the header is on the wire
  typedef enum logic [1:0] {
    STG_AW  = 2'd0,
    STG_SUB = 2'd1,
    STG_AR  = 2'd2
  } stage_e;

endpackage

// File: rtl/i2c_rd_sync.sv
`timescale 1ns/1ps
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rd_qtick.sv
`timescale 1ns/1ps
module i2c_rd_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_rd_phy.sv
`timescale 1ns/1ps
module i2c_rd_phy
  import i2c_rd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  cmd_valid,
  input  pcmd_e cmd,
  input  logic  wbit,
  input  logic  sda_in,
  output logic  active,
  output logic  done,
  output logic  rbit,
  output logic  scl_oe,
  output logic  sda_oe
);
  logic       active_q, active_d;
  logic [1:0] qc_q, qc_d;
  pcmd_e      cmd_q, cmd_d;
  logic       wbit_q, wbit_d;
  logic       rbit_q, rbit_d;
  logic       done_q, done_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;

  always_comb begin
    active_d = active_q;
    qc_d     = qc_q;
    cmd_d    = cmd_q;
    wbit_d   = wbit_q;
    rbit_d   = rbit_q;
    done_d   = 1'b0;
    scl_d    = scl_q;
    sda_d    = sda_q;
    if (!active_q) begin
      if (cmd_valid) begin
        active_d = 1'b1;
        qc_d     = 2'd0;
        cmd_d    = cmd;
        wbit_d   = wbit;
      end
    end else if (tick) begin
      qc_d = qc_q + 2'd1;
      case (qc_q)
        2'd0: begin  // SCL is low here except before an idle-bus start
          case (cmd_q)
            PCMD_START: sda_d = 1'b0;
            PCMD_STOP:  sda_d = 1'b1;
            PCMD_WRITE: sda_d = ~wbit_q;
            default:    sda_d = 1'b0;
          endcase
        end
        2'd1: scl_d = 1'b0;  // release SCL
        2'd2: begin  // SCL high: start/stop edge or sample point
          case (cmd_q)
            PCMD_START: sda_d = 1'b1;
            PCMD_STOP:  sda_d = 1'b0;
            default:    rbit_d = sda_in;
          endcase
        end
        default: begin
          if (cmd_q != PCMD_STOP) scl_d = 1'b1;
          active_d = 1'b0;
          done_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      qc_q     <= 2'd0;
      cmd_q    <= PCMD_START;
      wbit_q   <= 1'b0;
      rbit_q   <= 1'b1;
      done_q   <= 1'b0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      qc_q     <= qc_d;
      cmd_q    <= cmd_d;
      wbit_q   <= wbit_d;
      rbit_q   <= rbit_d;
      done_q   <= done_d;
      scl_q    <= scl_d;
      sda_q    <= sda_d;
    end
  end

  assign active = active_q;
  assign done   = done_q;
  assign rbit   = rbit_q;
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
endmodule

// File: rtl/i2c_regread_master.sv
`timescale 1ns/1ps
module i2c_regread_master
  import i2c_rd_pkg::*;
#(
  parameter int CLK_DIV     = 63,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] sub_addr,
  input  logic [CW-1:0] byte_cnt,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic          error,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe
);
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(DW - 1);
  localparam logic [CW-1:0]  ONE_LEFT = CW'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic  sda_s;
  logic  tick;
  logic  phy_active, phy_done, phy_rbit;
  logic  phy_valid, phy_wbit;
  pcmd_e phy_cmd;

  i2c_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(sda_i), .q(sda_s)
  );

  i2c_rd_qtick #(.QDIV(CLK_DIV)) u_qtick (
    .clk(clk), .rst_n(rst_sn), .run(phy_active), .tick(tick)
  );

  i2c_rd_phy u_phy (
    .clk(clk), .rst_n(rst_sn), .tick(tick),
    .cmd_valid(phy_valid), .cmd(phy_cmd), .wbit(phy_wbit),
    .sda_in(sda_s), .active(phy_active), .done(phy_done),
    .rbit(phy_rbit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  seq_e           state_q, state_d;
  stage_e         stage_q, stage_d;
  logic [DW-1:0]  shreg_q, shreg_d;
  logic [BCW-1:0] bitcnt_q, bitcnt_d;
  logic [CW-1:0]  remain_q, remain_d;
  logic [AW-1:0]  taddr_q, taddr_d;
  logic [DW-1:0]  sub_q, sub_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic           error_q, error_d;
  logic           rdv_q, rdv_d;
  logic [DW-1:0]  rdata_q, rdata_d;
  logic           in_xfer;

  assign in_xfer   = (state_q != S_IDLE);
  assign phy_valid = in_xfer && !phy_active && !phy_done;

  always_comb begin
    phy_cmd  = PCMD_START;
    phy_wbit = 1'b1;
    case (state_q)
      S_TX:    begin phy_cmd = PCMD_WRITE; phy_wbit = shreg_q[DW-1]; end
      S_TXACK: phy_cmd = PCMD_READ;
      S_RX:    phy_cmd = PCMD_READ;
      S_RXACK: begin phy_cmd = PCMD_WRITE; phy_wbit = (remain_q == ONE_LEFT); end
      S_STOP:  phy_cmd = PCMD_STOP;
      default: phy_cmd = PCMD_START;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    stage_d  = stage_q;
    shreg_d  = shreg_q;
    bitcnt_d = bitcnt_q;
    remain_d = remain_q;
    taddr_d  = taddr_q;
    sub_d    = sub_q;
    err_d    = err_q;
    rdata_d  = rdata_q;
    done_d   = 1'b0;
    error_d  = 1'b0;
    rdv_d    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (go) begin
          taddr_d  = tgt_addr;
          sub_d    = sub_addr;
          remain_d = byte_cnt;
          err_d    = 1'b0;
          if (byte_cnt == '0) begin
            done_d  = 1'b1;
            error_d = 1'b1;
          end else begin
            state_d = S_START;
            stage_d = STG_AW;
          end
        end
      end
      S_START: if (phy_done) begin
        shreg_d  = {taddr_q, (stage_q == STG_AR)};
        bitcnt_d = '0;
        state_d  = S_TX;
      end
      S_TX: if (phy_done) begin
        shreg_d  = {shreg_q[DW-2:0], 1'b0};
        bitcnt_d = bitcnt_q + 1'b1;
        if (bitcnt_q == BIT_LAST) state_d = S_TXACK;
      end
      S_TXACK: if (phy_done) begin
        bitcnt_d = '0;
        if (phy_rbit) begin
          err_d   = 1'b1;
          state_d = S_STOP;
        end else begin
          case (stage_q)
            STG_AW: begin
              stage_d = STG_SUB;
              shreg_d = sub_q;
              state_d = S_TX;
            end
            STG_SUB: begin
              stage_d = STG_AR;
              state_d = S_START;
            end
            default: state_d = S_RX;
          endcase
        end
      end
      S_RX: if (phy_done) begin
        shreg_d  = {shreg_q[DW-2:0], phy_rbit};
        bitcnt_d = bitcnt_q + 1'b1;
        if (bitcnt_q == BIT_LAST) begin
          rdata_d = {shreg_q[DW-2:0], phy_rbit};
          rdv_d   = 1'b1;
          state_d = S_RXACK;
        end
      end
      S_RXACK: if (phy_done) begin
        remain_d = remain_q - 1'b1;
        state_d  = (remain_q == ONE_LEFT) ? S_STOP : S_RX;
      end
      S_STOP: if (phy_done) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
        error_d = err_q;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= S_IDLE;
      stage_q  <= STG_AW;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      remain_q <= '0;
      taddr_q  <= '0;
      sub_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      error_q  <= 1'b0;
      rdv_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      stage_q  <= stage_d;
      shreg_q  <= shreg_d;
      bitcnt_q <= bitcnt_d;
      remain_q <= remain_d;
      taddr_q  <= taddr_d;
      sub_q    <= sub_d;
      err_q    <= err_d;
      done_q   <= done_d;
      error_q  <= error_d;
      rdv_q    <= rdv_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rd_data  = rdata_q;
  assign rd_valid = rdv_q;
  assign done     = done_q;
  assign error    = error_q;
endmodule

// File: rtl/i2c_regread_master_chk.sv
`timescale 1ns/1ps
module i2c_regread_master_chk
  import i2c_rd_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [CW-1:0] byte_cnt,
  input logic          in_xfer,
  input pcmd_e         phy_cmd,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          done,
  input logic          error,
  input logic          rd_valid
);
  // R8: with SCL released over two cycles, an SDA move must be a start or stop
  p_sda_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (phy_cmd == PCMD_START || phy_cmd == PCMD_STOP));

  // R1: zero count answered in the next cycle with done and error
  p_zero_count_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !in_xfer && byte_cnt == '0) |=> (done && error));

  // R1: zero count leaves the bus alone
  p_zero_count_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !in_xfer && byte_cnt == '0) |=> (!in_xfer && !scl_oe && !sda_oe));

  // R6: both lines released whenever no request is open
  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_xfer |-> (!scl_oe && !sda_oe));

  // R7: error only together with done
  p_error_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R5: bytes are delivered only inside a request
  p_valid_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> in_xfer);
endmodule

bind i2c_regread_master i2c_regread_master_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .go(go), .byte_cnt(byte_cnt),
  .in_xfer(in_xfer), .phy_cmd(phy_cmd), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .error(error), .rd_valid(rd_valid)
);

// File: tb/i2c_regread_master_test.sv
`timescale 1ns/1ps
module i2c_regread_master_test;
  localparam int DIV = 4;
  localparam logic [6:0] MYADDR = 7'h2C;
  localparam int T_IDLE = 0, T_ADDR = 1, T_SUB = 2, T_RD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, go;
  logic [6:0] tgt_addr;
  logic [7:0] sub_addr, byte_cnt, rd_data;
  logic       rd_valid, done, error, scl_oe, sda_oe, sda_i;
  logic       t_oe, scl_l, sda_l;

  assign scl_l = ~scl_oe;
  assign sda_l = ~(sda_oe | t_oe);
  assign sda_i = sda_l;

  i2c_regread_master #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .tgt_addr(tgt_addr),
    .sub_addr(sub_addr), .byte_cnt(byte_cnt), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .error(error), .scl_oe(scl_oe),
    .sda_i(sda_i), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic finished = 1'b0;
  logic clr = 1'b0;
  int nmode = 0;

  function automatic logic [7:0] dat(input logic [7:0] a);
    return (a * 8'd29) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // target model and bus monitor
  int ts, bitn, starts, stops, stops_at_rs, acks, nacks, rw0, rw1, hi_bad, hi_start;
  int rx_n, done_cnt;
  logic [7:0] sh, ptr, got_sub;
  logic rw, acked, mack, p_scl, p_sda, rise_seen;
  logic [7:0] rxb [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n || clr) begin
      ts = T_IDLE; bitn = 0; starts = 0; stops = 0; stops_at_rs = -1;
      acks = 0; nacks = 0; rw0 = 0; rw1 = 0; hi_bad = 0; hi_start = 0;
      rx_n = 0; done_cnt = 0; sh = 0; ptr = 0; got_sub = 8'hxx; rw = 0;
      acked = 0; mack = 0; p_scl = 1; p_sda = 1; rise_seen = 0; t_oe = 0;
    end else begin
      if (rd_valid) begin rxb[rx_n[7:0]] = rd_data; rx_n++; end
      if (done) done_cnt++;
      if (scl_l && p_scl && p_sda && !sda_l) begin
        starts++;
        if (starts == 2) stops_at_rs = stops;
        ts = T_ADDR; bitn = 0; t_oe = 0;
      end else if (scl_l && p_scl && !p_sda && sda_l) begin
        stops++; ts = T_IDLE; t_oe = 0; rise_seen = 0;
      end else if (scl_l && !p_scl) begin
        hi_start = cyc; rise_seen = 1;
        if (bitn < 8) sh = {sh[6:0], sda_l};
        if (ts == T_RD && bitn == 8) begin
          mack = !sda_l;
          if (mack) acks++; else nacks++;
        end
        bitn++;
      end else if (!scl_l && p_scl) begin
        if (rise_seen && (cyc - hi_start) != 2 * DIV) hi_bad++;
        if (ts == T_ADDR || ts == T_SUB) begin
          if (bitn == 8) begin
            if (ts == T_ADDR) begin
              rw = sh[0];
              if (rw) rw1++; else rw0++;
              acked = (sh[7:1] == MYADDR) && !(nmode == 3 && rw);
            end else begin
              got_sub = sh;
              acked = (nmode != 2);
            end
            t_oe = acked;
          end else if (bitn == 9) begin
            t_oe = 0; bitn = 0;
            if (!acked) ts = T_IDLE;
            else if (ts == T_ADDR && !rw) ts = T_SUB;
            else if (ts == T_ADDR) begin
              ts = T_RD; ptr = got_sub; t_oe = !dat(ptr)[7];
            end else ts = T_IDLE;
          end
        end else if (ts == T_RD) begin
          if (bitn >= 1 && bitn <= 7) t_oe = !dat(ptr)[7 - bitn];
          else if (bitn == 8) t_oe = 0;
          else if (bitn == 9) begin
            if (mack) begin
              ptr = ptr + 8'd1; bitn = 0; t_oe = !dat(ptr)[7];
            end else begin
              ts = T_IDLE; t_oe = 0;
            end
          end
        end
      end
      p_scl = scl_l; p_sda = sda_l;
    end
  end

  task automatic clear_mon();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
  endtask

  task automatic run_xfer(input logic [6:0] a, input logic [7:0] s, input int n,
                          input int mode, input bit inject);
    int exp_n, exp_starts, bad, first_bad;
    bit exp_err, err_seen;
    nmode = mode;
    clear_mon();
    @(negedge clk);
    tgt_addr = a; sub_addr = s; byte_cnt = n[7:0]; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (inject) begin
      repeat (300) @(negedge clk);
      tgt_addr = ~a; byte_cnt = 8'd0; go = 1'b1;
      @(negedge clk);
      go = 1'b0; tgt_addr = a;
    end
    while (!done) @(negedge clk);
    err_seen = error;
    repeat (40) @(negedge clk);
    exp_err = (a != MYADDR) || mode == 2 || mode == 3;
    exp_n = exp_err ? 0 : n;
    exp_starts = (a != MYADDR || mode == 2) ? 1 : 2;
    chk(err_seen == exp_err, exp_err ? "R7" : "R6", "error flag", int'(err_seen), int'(exp_err));
    chk(rx_n == exp_n, "R5", "byte count", rx_n, exp_n);
    bad = 0; first_bad = 0;
    for (int i = 0; i < exp_n && i < rx_n; i++)
      if (rxb[i] != dat(s + i[7:0])) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
    chk(bad == 0, "R5", "data bytes (first bad index value)",
        bad ? int'(rxb[first_bad]) : 0, bad ? int'(dat(s + first_bad[7:0])) : 0);
    chk(rw0 == 1, "R2", "address with direction 0", rw0, 1);
    if (a == MYADDR) chk(got_sub == s, "R3", "register index seen", int'(got_sub), int'(s));
    chk(starts == exp_starts, "R4", "start conditions", starts, exp_starts);
    if (exp_starts == 2) begin
      chk(stops_at_rs == 0, "R4", "stops before repeated start", stops_at_rs, 0);
      chk(rw1 == 1, "R4", "address with direction 1", rw1, 1);
    end
    chk(stops == 1, "R6", "stop conditions", stops, 1);
    if (!exp_err) begin
      chk(acks == n - 1, "R6", "master acknowledges", acks, n - 1);
      chk(nacks == 1, "R6", "master not-acknowledges", nacks, 1);
    end
    chk(hi_bad == 0, "R9", "SCL high widths off", hi_bad, 0);
    chk(done_cnt == 1, inject ? "R10" : "R7", "done pulses", done_cnt, 1);
    chk(!scl_oe && !sda_oe, "R6", "bus released after request", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    rst_n = 1'b0; go = 1'b0; tgt_addr = 0; sub_addr = 0; byte_cnt = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk(!done && !error && !rd_valid, "R6", "outputs after reset", int'({done, error, rd_valid}), 0);
    chk(!scl_oe && !sda_oe, "R6", "bus released after reset", int'({scl_oe, sda_oe}), 0);

    // R1: zero count
    clear_mon();
    @(negedge clk);
    tgt_addr = MYADDR; sub_addr = 8'h10; byte_cnt = 8'd0; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(done && error, "R1", "done and error after zero count", int'({done, error}), 3);
    repeat (60) @(negedge clk);
    chk(starts == 0, "R1", "start conditions for zero count", starts, 0);

    // directed cases
    run_xfer(MYADDR, 8'h3C, 1, 0, 1'b0);        // R6 single byte
    run_xfer(MYADDR, 8'h80, 4, 0, 1'b0);
    run_xfer(7'h2D,  8'h11, 3, 0, 1'b0);        // R7 address not acknowledged
    run_xfer(MYADDR, 8'h22, 3, 2, 1'b0);        // R7 index not acknowledged
    run_xfer(MYADDR, 8'h33, 3, 3, 1'b0);        // R7 read address not acknowledged
    run_xfer(MYADDR, 8'h05, 3, 0, 1'b1);        // R10 stray go
    run_xfer(MYADDR, 8'hF0, 255, 0, 1'b0);      // R5 index wrap, long burst

    // constrained random
    void'($urandom(32'd1234));
    for (int k = 0; k < 20; k++) begin
      int m, n, sel;
      logic [6:0] a;
      sel = $urandom_range(0, 9);
      m = (sel < 7) ? 0 : (sel - 6);
      a = MYADDR;
      if (m == 1) begin a = 7'h51; m = 0; end
      n = $urandom_range(1, 6);
      run_xfer(a, 8'($urandom_range(0, 255)), n, m, 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 190000) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule